// File: doc/BRIEF.md
# QSPI Page-Program Write Buffer

This block sits between a register port and the serial pins of a quad SPI flash controller and supplies the data phase of a page-program transaction. Software pushes 32-bit program words into an eight-entry FIFO, then issues a start command. The block pops words one at a time and shifts them out on the serial data lines, either one bit or four bits per serial clock. It keeps the serial clock, chip select and per-lane output enables in step with that shift.

The data phase is elastic. Software may keep pushing words while the transfer runs, and the stream continues without a break as long as each new word arrives before the word on the wire has finished. The transfer stops at the first word boundary where the FIFO is empty. It also stops unconditionally once one flash page (256 bytes) has gone out. If words are still waiting at that point, a flag records the fact.

Status outputs let software poll progress: the fill level, empty, full, busy, sticky overflow and leftover flags, and the number of bytes sent so far. A one-cycle done pulse marks the end of each transaction. The serial clock runs at half the system clock. Serial data changes only while the serial clock is low, so the flash samples it on the rising edge.

Top module: `qspi_page_writer`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, io_oe is 0, and busy, done, overflow and leftover are 0. fifo_empty is 1, and fill_level and bytes_sent are 0.
- R2: The FIFO holds 8 words. A push while not full is stored. fill_level gives the number of stored words, fifo_full is 1 at 8 words and fifo_empty is 1 at 0 words.
- R3: A push while fifo_full is 1 is discarded, even if a word leaves in the same cycle, and it sets overflow. overflow stays 1 until a start is accepted.
- R4: A start while idle is accepted. One clock later busy is 1, cs_n is 0 and io_out carries the first unit of the oldest word. A start while busy has no effect on the stream or on bytes_sent.
- R5: In quad mode, each serial clock carries 4 bits on io_out[3:0], starting with bits [3:0] of the word and moving up one nibble per clock. io_oe is 4'b1111 while cs_n is 0.
- R6: In single mode, each serial clock carries one bit on io_out[0], starting with bit 0 of the word. io_oe is 4'b0001 and io_out[3:1] is 0 while cs_n is 0.
- R7: While cs_n is 0, sclk alternates every clock and io_out changes only as sclk goes low. While cs_n is 1, sclk is 0 and io_oe is 0.
- R8: Words pushed during a transfer are sent in push order, with cs_n staying low, if they arrive before the current word finishes.
- R9: At a word boundary with the FIFO empty, the transfer ends and cs_n goes high, however few bytes have been sent.
- R10: After 256 bytes the transfer ends even if words remain. leftover is then 1 if the FIFO is not empty. It is cleared by the next accepted start, and the remaining words stay queued.
- R11: busy stays 1 from the accepted start through a one-cycle done pulse, and is 0 the clock after done. A start with an empty FIFO gives one cycle of busy with done, and cs_n stays 1.
- R12: The quad_en input (1 = quad, 0 = single) is sampled only when a start is accepted. Changes during a transfer do not alter its lane mode.
- R13: bytes_sent is cleared by an accepted start and counts completed bytes, 4 per word. It holds its value after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push one word into the FIFO |
| push_data | input | 32 | Word to push |
| start | input | 1 | Start command |
| quad_en | input | 1 | Lane mode for the next start: 1 quad, 0 single |
| fill_level | output | 4 | Words held in the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds 8 words |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| bytes_sent | output | 9 | Bytes sent in the current or last transaction |
| overflow | output | 1 | Sticky: a push was dropped |
| leftover | output | 1 | Page cap hit with words still queued |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data lanes |
| io_oe | output | 4 | Per-lane output enable |

## Verification
The bench keeps the FIFO fed during quad transfers until more than a page has been pushed. A design that counts the cap wrongly either sends a 65th word or stops early, and the leftover words and level then disagree with the count. Pushes made during a transfer check that the stream continues with no gap. A design that decides too early ends the transfer with cs_n high while words are still queued. A ninth push into a full FIFO must vanish from the stream, and a start with an empty FIFO must pulse done without lowering cs_n. Starts issued and lane modes flipped mid-transfer would show up as a reset byte count or as bits assembled in the wrong lane order.

// File: rtl/qpw_pkg.sv
package qpw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } qpw_state_e;

  localparam int LANES = 4;
endpackage

// File: rtl/qpw_fifo.sv
module qpw_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic              clr_ovf_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              push_ok, pop_ok;

  assign full_o  = (cnt_q == LVL_FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
    if (pop_ok)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + LVL_W'(1);
      2'b01:   cnt_d = cnt_q - LVL_W'(1);
      default: cnt_d = cnt_q;
    endcase
    ovf_d = (push_i & full_o) | (ovf_q & ~clr_ovf_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_q];
  assign level_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/qpw_shifter.sv
module qpw_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              quad_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [3:0]        io_o
);
  logic [WORD_W-1:0] sh_q, sh_d, src;
  logic [3:0]        io_q, io_d;

  always_comb begin
    sh_d = sh_q;
    io_d = io_q;
    src  = load_i ? word_i : sh_q;
    if (load_i || adv_i) begin
      if (quad_i) begin
        io_d = src[3:0];
        sh_d = {4'b0000, src[WORD_W-1:4]};
      end else begin
        io_d = {3'b000, src[0]};
        sh_d = {1'b0, src[WORD_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      io_q <= '0;
    end else begin
      sh_q <= sh_d;
      io_q <= io_d;
    end
  end

  assign io_o = io_q;
endmodule

// File: rtl/qpw_ctrl.sv
module qpw_ctrl
  import qpw_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PAGE_BYTES = 256,
  parameter int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             quad_en_i,
  input  logic             fifo_empty_i,
  output logic             pop_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             quad_sel_o,
  output logic             quad_o,
  output logic             start_ok_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic [CNT_W-1:0] bytes_o,
  output logic             leftover_o
);
  localparam int BEAT_W = $clog2(WORD_W);
  localparam logic [BEAT_W-1:0] LAST_S = BEAT_W'(WORD_W - 1);
  localparam logic [BEAT_W-1:0] LAST_Q = BEAT_W'(WORD_W / 4 - 1);
  localparam logic [CNT_W-1:0]  CAP    = CNT_W'(PAGE_BYTES);

  qpw_state_e        st_q, st_d;
  logic              ph_q, ph_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_after;
  logic              quad_q, quad_d;
  logic              left_q, left_d;
  logic              byte_end;

  assign start_ok_o = start_i & (st_q == ST_IDLE);
  assign byte_end   = (st_q == ST_SHIFT) & ph_q &
                      (quad_q ? (beat_q[0] == 1'b0) : (beat_q[2:0] == 3'd0));
  assign cnt_after  = cnt_q + CNT_W'(byte_end);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    beat_d = beat_q;
    cnt_d  = cnt_q;
    quad_d = quad_q;
    left_d = left_q;
    pop_o  = 1'b0;
    load_o = 1'b0;
    adv_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_d  = '0;
          left_d = 1'b0;
          quad_d = quad_en_i;
          ph_d   = 1'b0;
          if (fifo_empty_i) begin
            st_d = ST_TAIL;
          end else begin
            st_d   = ST_SHIFT;
            pop_o  = 1'b1;
            load_o = 1'b1;
            beat_d = quad_en_i ? LAST_Q : LAST_S;
          end
        end
      end
      ST_SHIFT: begin
        cnt_d = cnt_after;
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (beat_q != '0) begin
            adv_o  = 1'b1;
            beat_d = beat_q - BEAT_W'(1);
          end else if (cnt_after == CAP) begin
            st_d   = ST_TAIL;
            left_d = ~fifo_empty_i;
          end else if (fifo_empty_i) begin
            st_d = ST_TAIL;
          end else begin
            pop_o  = 1'b1;
            load_o = 1'b1;
            beat_d = quad_q ? LAST_Q : LAST_S;
          end
        end
      end
      ST_TAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      beat_q <= '0;
      cnt_q  <= '0;
      quad_q <= 1'b0;
      left_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      beat_q <= beat_d;
      cnt_q  <= cnt_d;
      quad_q <= quad_d;
      left_q <= left_d;
    end
  end

  assign quad_sel_o = (st_q == ST_IDLE) ? quad_en_i : quad_q;
  assign quad_o     = quad_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_TAIL);
  assign sclk_o     = (st_q == ST_SHIFT) & ph_q;
  assign cs_n_o     = (st_q != ST_SHIFT);
  assign bytes_o    = cnt_q;
  assign leftover_o = left_q;
endmodule

// File: rtl/qspi_page_writer.sv
module qspi_page_writer
  import qpw_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int PAGE_BYTES = 256,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [WORD_W-1:0] push_data,
  input  logic              start,
  input  logic              quad_en,
  output logic [LVL_W-1:0]  fill_level,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_sent,
  output logic              overflow,
  output logic              leftover,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);
  logic [1:0]        rs_q;
  logic              srst_n;
  logic              pop, load, adv, quad_sel, quad_act, start_ok;
  logic [WORD_W-1:0] head_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  qpw_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(srst_n), .push_i(push_en), .wdata_i(push_data),
    .pop_i(pop), .clr_ovf_i(start_ok), .rdata_o(head_word),
    .level_o(fill_level), .empty_o(fifo_empty), .full_o(fifo_full),
    .ovf_o(overflow)
  );

  qpw_ctrl #(.WORD_W(WORD_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .start_i(start), .quad_en_i(quad_en),
    .fifo_empty_i(fifo_empty), .pop_o(pop), .load_o(load), .adv_o(adv),
    .quad_sel_o(quad_sel), .quad_o(quad_act), .start_ok_o(start_ok),
    .busy_o(busy), .done_o(done), .sclk_o(sclk), .cs_n_o(cs_n),
    .bytes_o(bytes_sent), .leftover_o(leftover)
  );

  qpw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .load_i(load), .adv_i(adv),
    .quad_i(quad_sel), .word_i(head_word), .io_o(io_out)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign io_oe[l] = ~cs_n;
    end else begin : g_wide
      assign io_oe[l] = ~cs_n & quad_act;
    end
  end
endmodule

module qspi_page_writer_chk #(
  parameter int DEPTH      = 8,
  parameter int PAGE_BYTES = 256,
  parameter int LVL_W      = 4,
  parameter int CNT_W      = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             push_en,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             cs_n,
  input logic [3:0]       io_oe,
  input logic [3:0]       io_out,
  input logic [LVL_W-1:0] fill_level,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             overflow,
  input logic [CNT_W-1:0] bytes_sent
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH)); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && fifo_full) |=> overflow); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(start && !busy)) |=> overflow); // R3
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && io_oe == 4'b0001) |-> (io_out[3:1] == 3'b000)); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000 && !sclk)); // R7
  AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |=> !sclk); // R7
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sclk) |=> (!sclk || $stable(io_out))); // R7
  AST_PAGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_sent <= CNT_W'(PAGE_BYTES)); // R10
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R11
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done)); // R11
  AST_BYTES_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bytes_sent >= $past(bytes_sent))); // R13
endmodule

bind qspi_page_writer qspi_page_writer_chk #(
  .DEPTH(FIFO_DEPTH), .PAGE_BYTES(PAGE_BYTES), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .push_en(push_en), .busy(busy),
  .done(done), .sclk(sclk), .cs_n(cs_n), .io_oe(io_oe), .io_out(io_out),
  .fill_level(fill_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .overflow(overflow), .bytes_sent(bytes_sent)
);

// File: tb/sim_qspi_page_writer.sv
`timescale 1ns/1ps
module sim_qspi_page_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_en = 1'b0;
  logic [31:0] push_data = '0;
  logic        start = 1'b0;
  logic        quad_en = 1'b0;
  logic [3:0]  fill_level;
  logic        fifo_empty, fifo_full, busy, done, overflow, leftover;
  logic [8:0]  bytes_sent;
  logic        sclk, cs_n;
  logic [3:0]  io_out, io_oe;

  always #5 clk = ~clk;

  qspi_page_writer u0 (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
    .start(start), .quad_en(quad_en), .fill_level(fill_level),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .busy(busy), .done(done),
    .bytes_sent(bytes_sent), .overflow(overflow), .leftover(leftover),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe)
  );

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q [0:127];

  // serial-line monitor
  logic [31:0] cap_q [0:127];
  logic [31:0] cap_w = '0;
  int cap_n = 0, cap_bits = 0, done_cnt = 0, csfall_cnt = 0;
  int oe_err = 0, r7_err = 0;
  logic mon_quad = 1'b0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [3:0] prev_io = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (mon_quad ? (io_oe != 4'b1111)
                     : (io_oe != 4'b0001 || io_out[3:1] != 3'b000)) oe_err++;
        if (sclk && prev_sclk) r7_err++;
        if (sclk && !prev_sclk) begin
          if (io_out != prev_io) r7_err++;
          if (mon_quad) begin
            cap_w = {io_out, cap_w[31:4]};
            cap_bits += 4;
          end else begin
            cap_w = {io_out[0], cap_w[31:1]};
            cap_bits += 1;
          end
          if (cap_bits == 32) begin
            if (cap_n < 128) cap_q[cap_n] = cap_w;
            cap_n++;
            cap_bits = 0;
          end
        end
      end else if (io_oe != 4'b0000 || sclk) begin
        oe_err++;
      end
      if (prev_cs && !cs_n) csfall_cnt++;
      if (done) done_cnt++;
    end
    prev_sclk = sclk;
    prev_io   = io_out;
    prev_cs   = cs_n;
  end

  function automatic logic [3:0] first_unit(input logic q, input logic [31:0] w);
    return q ? w[3:0] : {3'b000, w[0]};
  endfunction

  function automatic int words_expected(input int n);
    return (n > 64) ? 64 : n;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic do_push(input logic [31:0] w);
    push_en   = 1'b1;
    push_data = w;
    @(negedge clk);
    push_en   = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R11 busy clears after transfer", 32'(busy), 32'd0);
  endtask

  // carry: words already queued (expected values in exp_q[0..carry-1])
  task automatic xfer(input logic q, input int carry, input int preload,
                      input int n_total, input bit disturb);
    int pushed;
    int nexp;
    int bad = 0;
    int first = 0;
    cap_n = 0; cap_bits = 0; done_cnt = 0; csfall_cnt = 0;
    oe_err = 0; r7_err = 0;
    for (int i = carry; i < carry + preload; i++) begin
      exp_q[i] = $urandom;
      do_push(exp_q[i]);
    end
    chk(fill_level == 4'(carry + preload), "R2 fill level before start",
        32'(fill_level), 32'(carry + preload));
    quad_en  = q;
    mon_quad = q;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    chk(!cs_n && busy, "R4 cs_n low and busy one clock after start",
        {30'd0, cs_n, busy}, 32'd1);
    chk(io_out == first_unit(q, exp_q[0]), "R4 first data unit on io_out",
        32'(io_out), 32'(first_unit(q, exp_q[0])));
    chk(!overflow, "R3 overflow cleared by accepted start", 32'(overflow), 32'd0);
    if (disturb) begin
      start   = 1'b1;
      quad_en = ~q;
      @(negedge clk);
      start   = 1'b0;
    end
    pushed = carry + preload;
    while (pushed < n_total) begin
      if (!fifo_full) begin
        exp_q[pushed] = $urandom;
        do_push(exp_q[pushed]);
        pushed++;
      end else begin
        @(negedge clk);
      end
    end
    wait_idle();
    @(negedge clk);
    nexp = words_expected(n_total);
    chk(cap_n == nexp && cap_bits == 0, "R9 R10 words sent", 32'(cap_n), 32'(nexp));
    for (int i = 0; i < nexp && i < cap_n; i++) begin
      if (cap_q[i] !== exp_q[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    end
    if (q) chk(bad == 0, "R5 quad stream content", cap_q[first], exp_q[first]);
    else   chk(bad == 0, "R6 single stream content", cap_q[first], exp_q[first]);
    chk(oe_err == 0, "R5 R6 lane enables and idle lines", 32'(oe_err), 32'd0);
    chk(r7_err == 0, "R7 data changes only with sclk low", 32'(r7_err), 32'd0);
    chk(csfall_cnt == 1, "R8 one chip-select window", 32'(csfall_cnt), 32'd1);
    chk(done_cnt == 1, "R11 one done pulse", 32'(done_cnt), 32'd1);
    chk(bytes_sent == 9'(4 * nexp), "R13 bytes_sent after transfer",
        32'(bytes_sent), 32'(4 * nexp));
    chk(leftover == (n_total > 64), "R10 leftover flag",
        32'(leftover), 32'(n_total > 64));
    chk(fill_level == 4'(n_total - nexp), "R10 words left queued",
        32'(fill_level), 32'(n_total - nexp));
    if (disturb) chk(1'b1, "R12 mode flip during transfer ignored", 32'd0, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_val;
    logic q;
    int n;
    int pre;
    seed_val = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk(cs_n && !sclk && io_oe == 4'b0000, "R1 serial lines idle after reset",
        {27'd0, cs_n, sclk, io_oe[2:0]}, 32'h10);
    chk(!busy && !done && !overflow && !leftover, "R1 flags clear after reset",
        {28'd0, busy, done, overflow, leftover}, 32'd0);
    chk(fifo_empty && fill_level == 4'd0 && bytes_sent == 9'd0,
        "R1 fifo empty and counters zero", 32'(fill_level), 32'd0);

    // R11: start with empty FIFO
    done_cnt = 0; csfall_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && done && cs_n, "R11 empty start gives busy with done, cs_n high",
        {29'd0, busy, done, cs_n}, 32'd7);
    @(negedge clk);
    chk(!busy && !done, "R11 busy drops after done", {30'd0, busy, done}, 32'd0);
    chk(bytes_sent == 9'd0 && csfall_cnt == 0, "R13 no bytes on empty start",
        32'(bytes_sent), 32'd0);

    // directed single and quad transfers
    xfer(1'b0, 0, 3, 3, 1'b0);
    xfer(1'b1, 0, 5, 5, 1'b0);
    // R8 refill mid-transfer, R4 and R12 disturbance
    xfer(1'b1, 0, 2, 20, 1'b1);
    xfer(1'b0, 0, 8, 12, 1'b1);

    // R3 overflow
    for (int i = 0; i < 8; i++) begin
      exp_q[i] = $urandom;
      do_push(exp_q[i]);
    end
    chk(fifo_full && !fifo_empty && fill_level == 4'd8, "R2 full at 8 words",
        32'(fill_level), 32'd8);
    do_push(32'hDEAD_BEEF);
    chk(overflow, "R3 push while full sets overflow", 32'(overflow), 32'd1);
    chk(fill_level == 4'd8, "R3 dropped push leaves level", 32'(fill_level), 32'd8);
    repeat (3) @(negedge clk);
    chk(overflow, "R3 overflow sticky", 32'(overflow), 32'd1);
    xfer(1'b1, 8, 0, 8, 1'b0);

    // R10 page cap
    xfer(1'b1, 0, 8, 70, 1'b0);
    for (int i = 0; i < 6; i++) exp_q[i] = exp_q[64 + i];
    xfer(1'b1, 6, 0, 6, 1'b0);

    // constrained random transfers
    for (int k = 0; k < 6; k++) begin
      q   = 1'($urandom & 32'd1);
      n   = 1 + int'($urandom % 32'd40);
      pre = 1 + int'($urandom % 32'((n < 8) ? n : 8));
      xfer(q, 0, pre, n, (k % 2) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule